// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital half of a 10-bit charge-redistribution converter. Once the sampling window closes, a one-cycle start strobe launches a binary search. The search runs one trial per result bit, from the most significant bit down to the least. In each trial the block drives a trial code to the capacitor-array switches and lets the array settle. It then reads one comparator bit and decides whether the bit under test stays set.

When the last bit is decided, the finished code is copied into a result register and a one-cycle done pulse is raised. An abort input stops a running search at once. The result register then keeps the value of the last conversion that finished.

The comparator here reports "summing node above trip point". That reading means the input lies below the trial code, so the bit under test is cleared. The analog array and the comparator are outside the block.

Top module: `sar_seq`

## Requirements
- R1: A start strobe taken while idle launches a conversion: busy_o is high from the next cycle on, and done_o rises exactly NBITS*TRIAL_CLKS cycles after the launching clock edge.
- R2: During trial k (k = 0 for the first trial), trial_o holds the bits already decided above position NBITS-1-k, holds bit NBITS-1-k at 1, and holds every lower bit at 0. trial_o is 0 whenever busy_o is low.
- R3: If cmp_above_i is 1 when a trial is sampled, the bit under test is cleared. If it is 0, the bit stays 1 for the rest of the conversion.
- R4: With an ideal comparator, an input at or above full scale (1023) yields 0x3FF, and an input at or below zero yields 0x000. Every input in between yields its own value.
- R5: Each trial code is held for TRIAL_CLKS cycles, and the comparator is sampled only in the last of them. Comparator values in the earlier settle cycles have no effect on the result.
- R6: result_o changes only in the cycle in which done_o is high.
- R7: done_o is a one-cycle pulse. It coincides with the new value on result_o and with busy_o going low.
- R8: A start strobe that arrives while busy_o is high is ignored. The running conversion keeps its timing and its result.
- R9: An abort while busy gives busy_o = 0 and trial_o = 0 in the next cycle, with no done pulse and result_o unchanged. This holds even when the abort arrives in the final sampling cycle. An abort while idle has no effect.
- R10: After reset, result_o, trial_o, busy_o and done_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle launch strobe at the end of sampling |
| abort_i | input | 1 | Cancel the running conversion |
| cmp_above_i | input | 1 | Comparator: summing node above trip point |
| trial_o | output | NBITS | Trial code driven to the array switches |
| result_o | output | NBITS | Last completed conversion result |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Call the clock edge that accepts start edge E0, and let T be TRIAL_CLKS. Trial k is then on trial_o from edge E0+k*T until edge E0+(k+1)*T, and done_o with the new result_o appears after edge E0+10*T. An abort takes effect at the first edge after it is raised.

The bench drives inputs and samples outputs on falling edges. It checks one trial code per T falling edges and checks done_o on the falling edge that follows the last trial. For the whole sweep, the comparator model gives an inverted answer during settle cycles, so any early sampling corrupts the result.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_TRIAL = 1'b1
  } sar_phase_e;

  // a trial needs at least one settle cycle plus the sampling cycle
  function automatic int unsigned trial_len(input int unsigned req);
    return (req < 2) ? 2 : req;
  endfunction

endpackage

// File: rtl/sar_trial_timer.sv
module sar_trial_timer #(
  parameter int unsigned TRIAL_CLKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic launch_i,
  input  logic kill_i,
  input  logic run_i,
  output logic sample_o
);
  localparam int unsigned CNT_W = (TRIAL_CLKS > 2) ? $clog2(TRIAL_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TRIAL_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign sample_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || launch_i || kill_i || sample_o) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sar_bit_pointer.sv
module sar_bit_pointer #(
  parameter int unsigned NBITS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch_i,
  input  logic             kill_i,
  input  logic             step_i,
  output logic [NBITS-1:0] ptr_o,
  output logic             last_o
);
  localparam logic [NBITS-1:0] TOP_BIT = {1'b1, {(NBITS-1){1'b0}}};

  assign last_o = ptr_o[0];

  always_ff @(posedge clk) begin
    if (rst || kill_i) begin
      ptr_o <= '0;
    end else if (launch_i) begin
      ptr_o <= TOP_BIT;
    end else if (step_i) begin
      ptr_o <= ptr_o >> 1;
    end
  end
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int unsigned NBITS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch_i,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             above_i,
  input  logic [NBITS-1:0] ptr_i,
  output logic [NBITS-1:0] code_o,
  output logic [NBITS-1:0] resolved_o
);
  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    // value of this bit once the current trial has been judged
    assign resolved_o[i] = ptr_i[i] ? (code_o[i] & ~above_i) : code_o[i];

    if (i == NBITS - 1) begin : g_top
      always_ff @(posedge clk) begin
        if (rst || clear_i) begin
          code_o[i] <= 1'b0;
        end else if (launch_i) begin
          code_o[i] <= 1'b1;
        end else if (step_i) begin
          code_o[i] <= resolved_o[i];
        end
      end
    end else begin : g_low
      always_ff @(posedge clk) begin
        if (rst || clear_i) begin
          code_o[i] <= 1'b0;
        end else if (launch_i) begin
          code_o[i] <= 1'b0;
        end else if (step_i) begin
          // next bit under test is raised as the current one is decided
          code_o[i] <= ptr_i[i+1] ? 1'b1 : resolved_o[i];
        end
      end
    end
  end
endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int unsigned NBITS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [NBITS-1:0] data_i,
  output logic [NBITS-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else if (load_i) begin
      q_o <= data_i;
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned NBITS      = 10,
  parameter int unsigned TRIAL_CLKS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             cmp_above_i,
  output logic [NBITS-1:0] trial_o,
  output logic [NBITS-1:0] result_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned TC = trial_len(TRIAL_CLKS);

  sar_phase_e       phase_q;
  logic             launch, kill, sample, step, finish, last;
  logic [NBITS-1:0] ptr, resolved;

  assign busy_o = (phase_q == PH_TRIAL);
  assign launch = start_i && !busy_o;
  assign kill   = busy_o && abort_i;
  assign step   = sample && !abort_i;
  assign finish = step && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      done_o  <= 1'b0;
    end else begin
      done_o <= finish;
      if (kill || finish) begin
        phase_q <= PH_IDLE;
      end else if (launch) begin
        phase_q <= PH_TRIAL;
      end
    end
  end

  sar_trial_timer #(.TRIAL_CLKS(TC)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .launch_i (launch),
    .kill_i   (kill),
    .run_i    (busy_o),
    .sample_o (sample)
  );

  sar_bit_pointer #(.NBITS(NBITS)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .launch_i (launch),
    .kill_i   (kill),
    .step_i   (step),
    .ptr_o    (ptr),
    .last_o   (last)
  );

  sar_code_reg #(.NBITS(NBITS)) u_code (
    .clk        (clk),
    .rst        (rst),
    .launch_i   (launch),
    .clear_i    (kill || finish),
    .step_i     (step),
    .above_i    (cmp_above_i),
    .ptr_i      (ptr),
    .code_o     (trial_o),
    .resolved_o (resolved)
  );

  sar_result_reg #(.NBITS(NBITS)) u_result (
    .clk    (clk),
    .rst    (rst),
    .load_i (finish),
    .data_i (resolved),
    .q_o    (result_o)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk
  import sar_seq_pkg::*;
#(
  parameter int unsigned NBITS      = 10,
  parameter int unsigned TRIAL_CLKS = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             abort_i,
  input logic [NBITS-1:0] trial_o,
  input logic [NBITS-1:0] result_o,
  input logic             busy_o,
  input logic             done_o
);
  localparam int unsigned LAT   = NBITS * trial_len(TRIAL_CLKS);
  localparam int unsigned LAT_W = $clog2(LAT + 2);

  logic             primed;
  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk) begin
    primed <= !rst;
    if (rst || !busy_o) lat_q <= '0;
    else if (lat_q != LAT_W'(LAT + 1)) lat_q <= lat_q + 1'b1;
  end

  a_r1_launch: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> busy_o);

  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (lat_q == LAT_W'(LAT)));

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (trial_o == '0));

  a_r2_test_bit_set: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (trial_o != '0));

  a_r6_result_hold: assert property (@(posedge clk) disable iff (rst)
    (primed && !done_o) |-> $stable(result_o));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  a_r9_abort: assert property (@(posedge clk) disable iff (rst)
    (busy_o && abort_i) |=> (!busy_o && !done_o));
endmodule

bind sar_seq sar_seq_chk #(.NBITS(NBITS), .TRIAL_CLKS(TRIAL_CLKS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .abort_i  (abort_i),
  .trial_o  (trial_o),
  .result_o (result_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
  localparam int NB = 10;
  localparam int T  = 3;
  localparam int FULL = (1 << NB) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          abort_i = 1'b0;
  logic          cmp_above_i;
  logic [NB-1:0] trial_o, result_o;
  logic          busy_o, done_o;

  int checks = 0;
  int errors = 0;
  int vin = 0;
  bit noise = 1'b0;
  int age = 0;
  logic [NB-1:0] prev_trial = '0;
  int last_res = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sar_seq #(.NBITS(NB), .TRIAL_CLKS(T)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i),
    .cmp_above_i(cmp_above_i), .trial_o(trial_o), .result_o(result_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  // ideal comparator: node above trip point when the input lies below the trial code;
  // with noise on it answers wrongly until the last cycle of a trial
  always_comb begin
    cmp_above_i = (int'(trial_o) > vin);
    if (noise && age < T - 1) cmp_above_i = ~cmp_above_i;
  end

  always @(negedge clk) begin
    if (trial_o != prev_trial) age <= 0;
    else if (age < 1000) age <= age + 1;
    prev_trial <= trial_o;
  end

  function automatic int clampv(input int v);
    if (v < 0) return 0;
    if (v > FULL) return FULL;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0 plain, 1 extra start mid-run, 2 abort mid-run, 3 abort on final sample cycle
  task automatic conv(input int v, input int mode);
    int ec;
    vin = v;
    ec = clampv(v);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R1 busy after start", int'(busy_o), 1);
    for (int k = 0; k < NB; k++) begin
      int b;
      int exp_t;
      b = NB - 1 - k;
      exp_t = ((ec >> (b + 1)) << (b + 1)) | (1 << b);
      chk(int'(trial_o) == exp_t, "R2 trial code", int'(trial_o), exp_t);
      chk(int'(result_o) == last_res, "R6 result held in run", int'(result_o), last_res);
      if (mode == 2 && k == 5) begin
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk(busy_o == 1'b0, "R9 abort busy", int'(busy_o), 0);
        chk(trial_o == '0, "R9 abort trial", int'(trial_o), 0);
        for (int j = 0; j < NB * T; j++) begin
          chk(done_o == 1'b0 && int'(result_o) == last_res, "R9 abort keeps result",
              int'(result_o), last_res);
          @(negedge clk);
        end
        return;
      end
      if (mode == 3 && k == NB - 1) begin
        repeat (T - 1) @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk(done_o == 1'b0, "R9 late abort no done", int'(done_o), 0);
        chk(busy_o == 1'b0, "R9 late abort busy", int'(busy_o), 0);
        chk(int'(result_o) == last_res, "R9 late abort result", int'(result_o), last_res);
        @(negedge clk);
        chk(done_o == 1'b0, "R9 late abort no done later", int'(done_o), 0);
        return;
      end
      if (mode == 1 && k == 4) begin
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (T - 1) @(negedge clk);
      end else begin
        repeat (T) @(negedge clk);
      end
    end
    chk(done_o == 1'b1, "R1 done latency", int'(done_o), 1);
    chk(int'(result_o) == ec, "R3 R4 R5 result", int'(result_o), ec);
    chk(busy_o == 1'b0, "R7 busy low with done", int'(busy_o), 0);
    last_res = ec;
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done single cycle", int'(done_o), 0);
    chk(int'(result_o) == ec, "R6 result kept", int'(result_o), ec);
    chk(busy_o == 1'b0, "R8 no relaunch", int'(busy_o), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(result_o == '0, "R10 reset result", int'(result_o), 0);
    chk(trial_o == '0, "R10 reset trial", int'(trial_o), 0);
    chk(busy_o == 1'b0, "R10 reset busy", int'(busy_o), 0);
    chk(done_o == 1'b0, "R10 reset done", int'(done_o), 0);

    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    @(negedge clk);
    chk(busy_o == 1'b0 && result_o == '0, "R9 idle abort", int'(result_o), 0);

    noise = 1'b0;
    conv(1500, 0);   // R4 above full scale
    conv(-9, 0);     // R4 below zero
    conv(FULL, 0);
    noise = 1'b1;    // R5 settle-cycle answers are wrong on purpose
    for (int v = 0; v <= FULL; v++) conv(v, 0);
    conv(5000, 0);
    conv(-1, 0);

    conv(600, 0);
    conv(77, 1);     // R8 start while busy
    conv(300, 2);    // R9 abort mid-run
    conv(845, 3);    // R9 abort on final sample
    conv(512, 0);    // recovery after abort

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule